// File: doc/BRIEF.md
# Double-Buffered Packet Receive Buffer

This block is the receive buffer of one bulk OUT endpoint. It holds two packet layers that take turns. The receive engine pushes bytes into whichever layer is being filled and marks the end of each packet. The local microcontroller drains the layer that is being read, one byte per read strobe. When it has finished a layer, it writes a clear request to the status register.

The block owns all of the layer bookkeeping:
- which layer is filled and which is drained;
- a ready flag for each layer;
- the byte count of each packet;
- an endpoint packet-ready status;
- an active-low interrupt, gated by an enable bit.

While both layers hold unread packets, a busy output tells the receive engine to refuse further packets.

A clear request only retires the layer being read. If the other layer already holds a finished packet, the status and the interrupt stay asserted, and reading moves straight on to that packet.

Top module: `pingpong_rx_buffer`

## Requirements
- R1: While `rst` is high at a clock edge, both layers are emptied and both fill and read point to layer 0. From the following cycle: `layerReady` = 00, `pktReady` = 0, `intN` = 1, `rxBusy` = 0 and `rdLeft` = 0. The interrupt enable resets to 0.
- R2: Bytes accepted with `rxValid` are stored in order in the filling layer. The first packet after reset goes to layer 0 (`layerReady` bit 0), and later packets alternate between layers 1 and 0. A pulse on `rxEop` sets that layer's ready bit in the next cycle and switches filling to the other layer. Bytes beyond DEPTH (64) in one packet are dropped, so the stored length is capped at 64. Zero-length packets are kept.
- R3: `pktReady` equals the ready flag of the layer being read. `rdLeft` shows the unread byte count of that layer.
- R4: A write to address 0 with data bit 1 set, made while `pktReady` is 1, is a clear request. It retires the read layer (clears its ready bit) and moves reading to the other layer, starting at that layer's first byte. If the other layer is not ready, `pktReady` is 0 and `intN` is 1 in the next cycle.
- R5: If the other layer already holds a complete packet when the clear request is made, `pktReady` stays 1 and `intN` stays asserted across the handoff. `rdLeft` then shows the new layer's length.
- R6: A write to address 0 with bit 1 clear, or any write to address 0 while `pktReady` is 0, changes no state.
- R7: A write to address 1 loads the interrupt enable from data bit 1. `intN` is low exactly when `pktReady` is 1 and the enable is set.
- R8: `rxBusy` is 1 while the layer due to be filled still holds an unread packet, that is, while both layers are ready. While `rxBusy` is 1, `rxValid` and `rxEop` are ignored and the stored packets stay intact.
- R9: `rdData` shows the byte at the read position. `rdStrobe` advances the position by one while `pktReady` is 1 and `rdLeft` is not 0, and is ignored otherwise.
- R10: Both orderings of the handoff deliver both packets intact. In the first, the second layer finishes filling after the first layer was retired. In the second, the first layer is retired after the second layer has filled.
- R11: A byte presented together with `rxEop` in the same cycle is the last byte of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxValid | input | 1 | Receive byte strobe from the serial engine |
| rxData | input | 8 | Receive byte |
| rxEop | input | 1 | End-of-packet pulse |
| rxBusy | output | 1 | Both layers occupied; packets are refused |
| rdStrobe | input | 1 | Microcontroller byte read strobe |
| rdData | output | 8 | Byte at the current read position |
| rdLeft | output | 7 | Unread bytes in the read layer |
| mcuWrEn | input | 1 | Register write strobe |
| mcuAddr | input | 1 | Register select: 0 = status clear, 1 = interrupt enable |
| mcuWrData | input | 8 | Register write data |
| pktReady | output | 1 | Endpoint packet-ready status |
| layerReady | output | 2 | Ready flags of layer 1 and layer 0 |
| intN | output | 1 | Interrupt, active low |

## Verification
The checker watches the flag bookkeeping on every cycle:
- each accepted end-of-packet adds exactly one ready flag;
- a busy buffer and rejected writes leave the flags unchanged;
- a clear request drops the status only when the other layer is empty, and holds it when both layers are full;
- every accepted read strobe lowers the unread count by one;
- the interrupt never asserts without a ready packet.

Only the bench's scenarios can show that bytes come back in order and intact. They cover every packet length from 0 to 66, including truncation past 64 and the byte that arrives together with end-of-packet. They also confirm that the held packet survives a refused third packet, and that both handoff orderings deliver both packets.

// File: rtl/pingpong_rx_pkg.sv
package pingpong_rx_pkg;

  // Strobes from the control to the datapath, valid for one cycle.
  typedef struct packed {
    logic wrByte;   // store rxData into the filling layer
    logic commit;   // close the packet in the filling layer
    logic rdStep;   // advance the read position
    logic rdSwap;   // restart reading in the other layer
    logic wrLayer;  // index of the filling layer
    logic rdLayer;  // index of the read layer
  } rxStrobe_t;

endpackage

// File: rtl/pingpong_rx_datapath.sv
module pingpong_rx_datapath
  import pingpong_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  rxStrobe_t     st,
  input  logic [7:0]    rxData,
  output logic          wrFull,
  output logic [7:0]    rdData,
  output logic [CW-1:0] rdLeft
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LAYERS = 2;

  logic [7:0]    layerMem [LAYERS][DEPTH];
  logic [CW-1:0] pktLen   [LAYERS];
  logic [CW-1:0] wrCount;
  logic [CW-1:0] rdPtr;

  assign wrFull = (wrCount == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (st.wrByte) layerMem[st.wrLayer][wrCount[AW-1:0]] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (rst)            wrCount <= '0;
    else if (st.commit) wrCount <= '0;
    else if (st.wrByte) wrCount <= wrCount + CW'(1);
  end

  for (genvar g = 0; g < LAYERS; g++) begin : g_len
    always_ff @(posedge clk) begin
      if (rst)
        pktLen[g] <= '0;
      else if (st.commit && (st.wrLayer == 1'(g)))
        pktLen[g] <= wrCount + CW'(st.wrByte);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            rdPtr <= '0;
    else if (st.rdSwap) rdPtr <= '0;
    else if (st.rdStep) rdPtr <= rdPtr + CW'(1);
  end

  assign rdData = layerMem[st.rdLayer][rdPtr[AW-1:0]];
  assign rdLeft = pktLen[st.rdLayer] - rdPtr;

endmodule

// File: rtl/pingpong_rx_control.sv
module pingpong_rx_control
  import pingpong_rx_pkg::*;
#(
  parameter int          CW       = 7,
  parameter logic [7:0]  CLR_MASK = 8'h02,
  parameter logic [7:0]  IE_MASK  = 8'h02
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxValid,
  input  logic          rxEop,
  input  logic          rdStrobe,
  input  logic          mcuWrEn,
  input  logic          mcuAddr,
  input  logic [7:0]    mcuWrData,
  input  logic          wrFull,
  input  logic [CW-1:0] rdLeft,
  output rxStrobe_t     st,
  output logic          rxBusy,
  output logic          pktReady,
  output logic [1:0]    layerReady,
  output logic          intN
);

  logic [1:0] readyQ;
  logic       wrSelQ;
  logic       rdSelQ;
  logic       ieQ;
  logic       busy;
  logic       clrHit;
  logic       commitNow;

  always_comb begin
    busy      = readyQ[wrSelQ];
    commitNow = rxEop && !busy;
    clrHit    = mcuWrEn && (mcuAddr == 1'b0) && (|(mcuWrData & CLR_MASK))
                && readyQ[rdSelQ];
    st.wrByte  = rxValid && !busy && !wrFull;
    st.commit  = commitNow;
    st.rdStep  = rdStrobe && readyQ[rdSelQ] && (rdLeft != '0) && !clrHit;
    st.rdSwap  = clrHit;
    st.wrLayer = wrSelQ;
    st.rdLayer = rdSelQ;
  end

  // commit and clear never address the same layer: commit needs the
  // filling layer empty, clear needs the read layer full.
  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (commitNow && (wrSelQ == 1'(g)))     readyQ[g] <= 1'b1;
        else if (clrHit && (rdSelQ == 1'(g)))   readyQ[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrSelQ <= 1'b0;
      rdSelQ <= 1'b0;
      ieQ    <= 1'b0;
    end else begin
      if (commitNow) wrSelQ <= !wrSelQ;
      if (clrHit)    rdSelQ <= !rdSelQ;
      if (mcuWrEn && (mcuAddr == 1'b1)) ieQ <= |(mcuWrData & IE_MASK);
    end
  end

  assign rxBusy     = busy;
  assign pktReady   = readyQ[rdSelQ];
  assign layerReady = readyQ;
  assign intN       = !(readyQ[rdSelQ] && ieQ);

endmodule

// File: rtl/pingpong_rx_buffer.sv
module pingpong_rx_buffer
  import pingpong_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxValid,
  input  logic [7:0]    rxData,
  input  logic          rxEop,
  output logic          rxBusy,
  input  logic          rdStrobe,
  output logic [7:0]    rdData,
  output logic [CW-1:0] rdLeft,
  input  logic          mcuWrEn,
  input  logic          mcuAddr,
  input  logic [7:0]    mcuWrData,
  output logic          pktReady,
  output logic [1:0]    layerReady,
  output logic          intN
);

  rxStrobe_t st;
  logic      wrFull;

  pingpong_rx_control #(.CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .rxValid(rxValid), .rxEop(rxEop),
    .rdStrobe(rdStrobe), .mcuWrEn(mcuWrEn), .mcuAddr(mcuAddr),
    .mcuWrData(mcuWrData), .wrFull(wrFull), .rdLeft(rdLeft), .st(st),
    .rxBusy(rxBusy), .pktReady(pktReady), .layerReady(layerReady),
    .intN(intN)
  );

  pingpong_rx_datapath #(.DEPTH(DEPTH), .CW(CW)) u_data (
    .clk(clk), .rst(rst), .st(st), .rxData(rxData), .wrFull(wrFull),
    .rdData(rdData), .rdLeft(rdLeft)
  );

endmodule

// File: rtl/pingpong_rx_checker.sv
module pingpong_rx_checker #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          rxEop,
  input logic          rxBusy,
  input logic          rdStrobe,
  input logic [CW-1:0] rdLeft,
  input logic          mcuWrEn,
  input logic          mcuAddr,
  input logic [7:0]    mcuWrData,
  input logic          pktReady,
  input logic [1:0]    layerReady,
  input logic          intN
);

  logic clrHit, eopTaken;
  assign clrHit   = mcuWrEn && !mcuAddr && mcuWrData[1] && pktReady;
  assign eopTaken = rxEop && !rxBusy;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (layerReady == 2'b00 && !pktReady && intN && !rxBusy && rdLeft == '0));

  a_r2_commit_adds_flag: assert property (@(posedge clk) disable iff (rst)
    (eopTaken && !clrHit) |=> ($countones(layerReady) == $countones($past(layerReady)) + 1));

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clrHit && $countones(layerReady) == 1 && !eopTaken) |=> (!pktReady && intN));

  a_r5_clear_refused: assert property (@(posedge clk) disable iff (rst)
    (clrHit && layerReady == 2'b11) |=> pktReady);

  a_r6_no_change: assert property (@(posedge clk) disable iff (rst)
    (!clrHit && !eopTaken) |=> $stable(layerReady));

  a_r7_int_needs_ready: assert property (@(posedge clk) disable iff (rst)
    !intN |-> pktReady);

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (rxBusy && !clrHit) |=> $stable(layerReady));

  a_r9_read_step: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && pktReady && rdLeft != '0 && !clrHit) |=> (rdLeft == $past(rdLeft) - CW'(1)));

  a_r2_len_cap: assert property (@(posedge clk) disable iff (rst)
    rdLeft <= CW'(DEPTH));

endmodule

bind pingpong_rx_buffer pingpong_rx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/pingpong_rx_buffer_test.sv
module pingpong_rx_buffer_test;
  localparam int DEPTH = 64;
  localparam int CW = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic rxValid = 1'b0, rxEop = 1'b0, rdStrobe = 1'b0;
  logic [7:0] rxData = '0, mcuWrData = '0;
  logic mcuWrEn = 1'b0, mcuAddr = 1'b0;
  logic rxBusy, pktReady, intN;
  logic [7:0] rdData;
  logic [CW-1:0] rdLeft;
  logic [1:0] layerReady;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [1:0] expReady = '0;
  bit mWr = 0, mRd = 0, ie = 0;

  always #5 clk = !clk;

  pingpong_rx_buffer uut (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byteOf(int tag, int i);
    return 8'((tag * 37 + i * 5 + 1) & 255);
  endfunction

  task automatic checkState(string req);
    chk(layerReady == expReady, {req, " layerReady"}, layerReady, expReady);
    chk(pktReady == expReady[mRd], {req, " pktReady"}, pktReady, expReady[mRd]);
    chk(intN == !(expReady[mRd] && ie), "R7 intN", intN, !(expReady[mRd] && ie));
    chk(rxBusy == expReady[mWr], "R8 rxBusy", rxBusy, expReady[mWr]);
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic sendPkt(int len, int tag, bit eopWithLast, bit model);
    for (int i = 0; i < len; i++) begin
      rxValid = 1'b1;
      rxData  = byteOf(tag, i);
      rxEop   = (eopWithLast && i == len - 1);
      @(negedge clk);
    end
    rxValid = 1'b0;
    if (!(eopWithLast && len > 0)) begin
      rxEop = 1'b1;
      @(negedge clk);
    end
    rxEop = 1'b0;
    if (model && !expReady[mWr]) begin
      expReady[mWr] = 1'b1;
      mWr = !mWr;
    end
  endtask

  task automatic mcuWrite(bit addr, logic [7:0] data);
    mcuWrEn = 1'b1; mcuAddr = addr; mcuWrData = data;
    @(negedge clk);
    mcuWrEn = 1'b0; mcuWrData = '0;
  endtask

  task automatic clearReq();
    mcuWrite(1'b0, 8'h02);
    if (expReady[mRd]) begin
      expReady[mRd] = 1'b0;
      mRd = !mRd;
    end
  endtask

  task automatic readPkt(int len, int tag, string req);
    int exp = (len > DEPTH) ? DEPTH : len;
    chk(rdLeft == CW'(exp), {req, " R3 rdLeft"}, rdLeft, exp);
    rdStrobe = 1'b1;
    for (int i = 0; i < exp; i++) begin
      chk(rdData == byteOf(tag, i), {req, " R2 rdData"}, rdData, byteOf(tag, i));
      @(negedge clk);
    end
    // strobe with nothing left is ignored (R9)
    @(negedge clk);
    rdStrobe = 1'b0;
    chk(rdLeft == '0, "R9 rdLeft after drain", rdLeft, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(layerReady == 2'b00, "R1 layerReady", layerReady, 0);
    chk(pktReady == 1'b0, "R1 pktReady", pktReady, 0);
    chk(intN == 1'b1, "R1 intN", intN, 1);
    chk(rxBusy == 1'b0, "R1 rxBusy", rxBusy, 0);
    chk(rdLeft == '0, "R1 rdLeft", rdLeft, 0);
    rst = 1'b0;
    @(negedge clk);

    // R6: clear request with nothing ready has no effect
    mcuWrite(1'b0, 8'h02);
    checkState("R6 idle clear");

    for (int len = 0; len <= 66; len++) begin
      int tagA = len * 2;
      int tagB = len * 2 + 1;
      int lenB = (len * 13 + 5) % 67;
      bit eopW = (len % 3 == 0);
      ie = (len % 8 < 4);
      mcuWrite(1'b1, ie ? 8'h02 : 8'hFD);
      if (len % 2 == 0) begin
        // R10 ordering: retire first layer, then the other fills
        sendPkt(len, tagA, eopW, 1);
        checkState("R2 first commit");
        mcuWrite(1'b0, 8'hFD); // R6: bit 1 clear, no effect
        checkState("R6 bit1 clear");
        readPkt(len, tagA, "R11 R10 a");
        clearReq();
        checkState("R4 clear drops");
        sendPkt(lenB, tagB, !eopW, 1);
        checkState("R2 second commit");
        readPkt(lenB, tagB, "R10 a second");
        clearReq();
        checkState("R4 clear drops second");
      end else begin
        // R10 ordering: both filled before the first is retired
        sendPkt(len, tagA, eopW, 1);
        sendPkt(lenB, tagB, !eopW, 1);
        checkState("R8 both full");
        sendPkt(5, 255, 1'b0, 0); // refused third packet
        checkState("R8 refused packet");
        readPkt(len, tagA, "R10 b first");
        clearReq();
        checkState("R5 clear refused");
        chk(pktReady == 1'b1, "R5 pktReady held", pktReady, 1);
        readPkt(lenB, tagB, "R8 R10 b second");
        clearReq();
        checkState("R4 final clear");
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule